// File: doc/BRIEF.md
# Floating-Point Ordering Comparator on a Signed Integer Datapath

This block orders two W-bit words with a single signed two's-complement comparator. In integer mode the word pair is compared as signed integers. In float mode the same pair is read as IEEE-754 bit patterns. Such patterns sort correctly as sign-magnitude integers because their exponents are biased. The block gets that order from the two's-complement result by inverting the less/greater decision when both sign bits are set. Under this order a positive NaN lands above positive infinity and a negative NaN lands below negative infinity. In float mode the two zeros are forced equal. A separate flag reports that the pair is unordered.

Operands arrive on a valid/ready input stream. Results leave on a valid/ready output stream through one register stage. The input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and `out_valid` are held unchanged and no new operand pair is taken. The width W is a parameter (32 or 64); the exponent field is 8 bits wide for 32 and 11 bits wide for 64, and the fraction takes the remaining low bits below it.

Top module: `ordered_compare`

## Requirements
- R1: With `mode_flt`=0 the flags give the signed two's-complement order of `a_word` against `b_word` (for example 32'hFFFFFFFE is less than 32'hFFFFFFFF).
- R2: With `mode_flt`=1 the flags give the sign-magnitude order: pairs with one or no sign bit set keep the signed order, and for two negative operands less and greater are swapped (for example -1.0 is greater than -2.0).
- R3: With `mode_flt`=1 a positive NaN pattern compares greater than positive infinity, and a negative NaN pattern compares less than negative infinity.
- R4: With `mode_flt`=1 a pair whose bits below the sign are all zero (+0 and -0 in any mix) reports equal. With `mode_flt`=0, 32'h80000000 against zero reports less.
- R5: `unord` is 1 only in float mode and only when either operand has an all-ones exponent field and a nonzero fraction. The less, equal and greater flags are still produced for that pair.
- R6: While `out_valid` is high, exactly one of `lt`, `eq` and `gt` is 1.
- R7: An accepted pair produces its result with `out_valid` high on the next clock edge.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and all outputs stay unchanged.
- R9: While `out_valid` is 0, all four flags are 0. Reset clears `out_valid` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| a_word | input | W | Left operand |
| b_word | input | W | Right operand |
| mode_flt | input | 1 | 1 = float ordering, 0 = signed integer |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| lt | output | 1 | a below b |
| eq | output | 1 | a equal to b |
| gt | output | 1 | a above b |
| unord | output | 1 | Float pair contains a NaN |

## Verification
The assertions check the stream rules on every cycle. These are the one-hot flags while valid, the quiet flags while idle, the result appearing the cycle after acceptance, and holding under back-pressure. They also check two data properties whenever a pair is accepted: zeros compare equal in float mode, and `unord` stays low in integer mode. Whether the ordering itself is right can only be shown by the bench's vectors. These cover the swap for two negative operands, the placement of NaN patterns around both infinities, and raw integer patterns that look like floats.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic unord;
  } cmp_flags_t;

  // Exponent field width for a given word width (double or single layout).
  function automatic int exp_bits(input int w);
    return (w >= 64) ? 11 : 8;
  endfunction

endpackage

// File: rtl/fcmp_nan_probe.sv
module fcmp_nan_probe #(
  parameter int W = 32
) (
  input  logic [W-2:0] mag,
  output logic         is_nan
);
  localparam int EXP_W  = fcmp_pkg::exp_bits(W);
  localparam int FRAC_W = W - 1 - EXP_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = mag[W-2 -: EXP_W];
  assign frac_f = mag[FRAC_W-1:0];
  assign is_nan = (&exp_f) & (|frac_f);
endmodule

// File: rtl/fcmp_raw_order.sv
module fcmp_raw_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         raw_lt,
  output logic         raw_eq
);
  assign raw_lt = $signed(a) < $signed(b);
  assign raw_eq = (a == b);
endmodule

// File: rtl/fcmp_order_fix.sv
module fcmp_order_fix (
  input  logic                   raw_lt,
  input  logic                   raw_eq,
  input  logic                   both_neg,
  input  logic                   both_zero,
  input  logic                   flt,
  input  logic                   any_nan,
  output fcmp_pkg::cmp_flags_t   flags
);
  logic flip;
  logic same;
  logic below;

  always_comb begin
    flip        = flt & both_neg;
    same        = raw_eq | (flt & both_zero);
    below       = raw_lt ^ flip;
    flags.eq    = same;
    flags.lt    = ~same & below;
    flags.gt    = ~same & ~below;
    flags.unord = flt & any_nan;
  end
endmodule

// File: rtl/ordered_compare.sv
module ordered_compare #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] a_word,
  input  logic [W-1:0] b_word,
  input  logic         mode_flt,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         lt,
  output logic         eq,
  output logic         gt,
  output logic         unord
);
  import fcmp_pkg::*;

  localparam int NOPS = 2;

  logic [W-1:0] ops [NOPS];
  logic [NOPS-1:0] nan_v;
  logic [NOPS-1:0] zero_v;
  logic [NOPS-1:0] neg_v;
  logic raw_lt, raw_eq;
  cmp_flags_t next_f, held_f;
  logic accept;

  assign ops[0] = a_word;
  assign ops[1] = b_word;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fcmp_nan_probe #(.W(W)) u_nan (
      .mag    (ops[g][W-2:0]),
      .is_nan (nan_v[g])
    );
    assign zero_v[g] = ~|ops[g][W-2:0];
    assign neg_v[g]  = ops[g][W-1];
  end

  fcmp_raw_order #(.W(W)) u_raw (
    .a      (a_word),
    .b      (b_word),
    .raw_lt (raw_lt),
    .raw_eq (raw_eq)
  );

  fcmp_order_fix u_fix (
    .raw_lt    (raw_lt),
    .raw_eq    (raw_eq),
    .both_neg  (&neg_v),
    .both_zero (&zero_v),
    .flt       (mode_flt),
    .any_nan   (|nan_v),
    .flags     (next_f)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held_f    <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      held_f    <= next_f;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      held_f    <= '0;
    end
  end

  assign lt    = held_f.lt;
  assign eq    = held_f.eq;
  assign gt    = held_f.gt;
  assign unord = held_f.unord;
endmodule

// File: rtl/fcmp_checker.sv
module fcmp_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] a_word,
  input logic [W-1:0] b_word,
  input logic         mode_flt,
  input logic         out_valid,
  input logic         out_ready,
  input logic         lt,
  input logic         eq,
  input logic         gt,
  input logic         unord
);
  logic took;
  assign took = in_valid & in_ready;

  assert_one_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({lt, eq, gt}) == 1);

  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ({lt, eq, gt, unord} == 4'b0));

  assert_next_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> out_valid);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({lt, eq, gt, unord})));

  assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_zero_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (took && mode_flt && a_word[W-2:0] == '0 && b_word[W-2:0] == '0) |=> eq);

  assert_int_ordered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !mode_flt) |=> !unord);
endmodule

bind ordered_compare fcmp_checker #(.W(W)) u_fcmp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .a_word    (a_word),
  .b_word    (b_word),
  .mode_flt  (mode_flt),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .lt        (lt),
  .eq        (eq),
  .gt        (gt),
  .unord     (unord)
);

// File: tb/test_ordered_compare.sv
module test_ordered_compare;
  localparam int W = 32;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] a_word = '0;
  logic [W-1:0] b_word = '0;
  logic mode_flt = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic lt, eq, gt, unord;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ordered_compare #(.W(W)) i_ordered_compare (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_word(a_word), .b_word(b_word), .mode_flt(mode_flt),
    .out_valid(out_valid), .out_ready(out_ready),
    .lt(lt), .eq(eq), .gt(gt), .unord(unord)
  );

  // {mode, a, b, expected lt/eq/gt/unord}
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, 32'h3F800000, 32'h40000000, 4'b1000}, // R2 1.0 < 2.0
    {1'b1, 32'hBF800000, 32'hC0000000, 4'b0010}, // R2 -1.0 > -2.0
    {1'b1, 32'hC0000000, 32'hBF800000, 4'b1000}, // R2 -2.0 < -1.0
    {1'b1, 32'hBF800000, 32'h3F800000, 4'b1000}, // R2 mixed signs
    {1'b1, 32'h00000000, 32'h80000000, 4'b0100}, // R4 +0 == -0
    {1'b1, 32'h80000000, 32'h00000000, 4'b0100}, // R4 -0 == +0
    {1'b1, 32'h7FC00000, 32'h7F800000, 4'b0011}, // R3 +NaN > +Inf
    {1'b1, 32'hFFC00000, 32'hFF800000, 4'b1001}, // R3 -NaN < -Inf
    {1'b1, 32'h7F800000, 32'hFFC00000, 4'b0011}, // R5 +Inf vs -NaN
    {1'b1, 32'h3F800000, 32'h3F800000, 4'b0100}, // R2 equal
    {1'b1, 32'hBF800000, 32'hBF800000, 4'b0100}, // R2 equal negatives
    {1'b1, 32'hFF800000, 32'hBF800000, 4'b1000}, // R2 -Inf < -1.0
    {1'b0, 32'h80000000, 32'h00000000, 4'b1000}, // R4 int raw zero patterns
    {1'b0, 32'hFFFFFFFF, 32'h00000001, 4'b1000}, // R1 -1 < 1
    {1'b0, 32'h7FC00000, 32'h7F800000, 4'b0010}, // R5 int mode no unord
    {1'b0, 32'h00000005, 32'h00000005, 4'b0100}, // R1 equal
    {1'b0, 32'hFFFFFFFE, 32'hFFFFFFFF, 4'b1000}  // R1 no swap in int mode
  };

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got {valid,ready,lt,eq,gt,unord}=%b expected %b", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", {out_valid, in_ready, lt, eq, gt, unord}, 6'b010000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      mode_flt = VEC[i][68];
      a_word   = VEC[i][67:36];
      b_word   = VEC[i][35:4];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R1/R2/R3/R4/R5/R7 vector %0d", i),
            {out_valid, in_ready, lt, eq, gt, unord}, {2'b11, VEC[i][3:0]});
    end
    @(negedge clk);
    check("R9 idle after drain", {out_valid, in_ready, lt, eq, gt, unord}, 6'b010000);

    // R8 back-pressure
    out_ready = 1'b0;
    mode_flt = 1'b1; a_word = 32'h3F800000; b_word = 32'h40000000; in_valid = 1'b1;
    @(negedge clk);
    check("R8 first result stalled", {out_valid, in_ready, lt, eq, gt, unord}, 6'b101000);
    a_word = 32'h40000000; b_word = 32'h3F800000;
    @(negedge clk);
    check("R8 held under stall", {out_valid, in_ready, lt, eq, gt, unord}, 6'b101000);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second taken after release", {out_valid, in_ready, lt, eq, gt, unord}, 6'b110010);
    @(negedge clk);
    check("R9 flags cleared when drained", {out_valid, in_ready, lt, eq, gt, unord}, 6'b010000);

    // R9 reset mid-stream
    mode_flt = 1'b0; a_word = 32'd1; b_word = 32'd2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears result", {out_valid, in_ready, lt, eq, gt, unord}, 6'b010000);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule